// File: doc/BRIEF.md
# LED Matrix Row-Scan Refresh Controller

This block refreshes an LED array of 20 columns by 8 rows, one row at a time. It takes a display oscillator that arrives as a one-cycle tick pulse. When the oscillator comes from an external source and the divide flag is set, the tick can be divided by 8. Each display tick moves a frame position forward. The frame position is a 3-bit row number and a 6-bit slot cycle.

From that position and a 7-bit brightness control word, a small state machine decides whether the current row is in one of four states:
- `ST_GAP`: the forced dark gap at the start of every row slot.
- `ST_LIT`: the brightness-dependent lit window.
- `ST_DARK`: the unlit remainder of the slot.
- `ST_SLEEP`: the display is asleep.

Row and column enables are produced only in `ST_LIT`. The column enables read the 160-bit dot latch, and an external blank input can force them off.

State transitions, evaluated at every clock from the frame position the counters will hold after that edge:
- `ST_SLEEP` to `ST_GAP`, `ST_LIT` or `ST_DARK` when the wake bit is high (wake).
- Any running state to `ST_SLEEP` when the wake bit is low (doze).
- `ST_GAP` to `ST_LIT` when the gap ends (light). When the on-time is zero, the gap goes to `ST_DARK` instead.
- `ST_LIT` to `ST_DARK` when the on-time is spent (extinguish).
- `ST_DARK` or `ST_LIT` to `ST_GAP` at the next row slot (next-row).

The reset state is `ST_SLEEP`.

Top module: `led_row_scanner`

## Requirements
- R1: A frame is 512 display ticks: rows 0 to 7 in ascending order, each owning 64 consecutive ticks. After row 7, tick 63, the position returns to row 0, tick 0 with no extra cycle.
- R2: In slot ticks 0 to 3 of every row, `row_en` and `col_en` are all zero.
- R3: `ctrl_word0[3:0]` is the brightness code. The row is lit for slot ticks 4 to 4+T-1. T is 0, 1, 2, 3, 4, 5, 7, 9, 11, 14, 18, 22, 28, 36, 48 or 60 for codes 0 to 15, so a frame holds 8*T lit ticks.
- R4: `row_en` is one-hot with bit r set for the current row r during the lit window, and all zero otherwise.
- R5: Column k enable equals `dot_latch[8*k + r]` during the lit window of row r. During row 0 all columns are off whatever the dots hold.
- R6: `blank` high forces every `col_en` bit to zero without changing `row_en`.
- R7: `ctrl_word0[6]` low is sleep. From the next clock edge, `row_en`, `col_en` and `peak_code` are zero and the frame position and divider hold. When the bit returns high, scanning resumes from the held position.
- R8: `peak_code` equals `ctrl_word0[5:4]` while awake and is zero while asleep.
- R9: With `ext_src` and `prescale_div8` both high, every 8th oscillator tick is a display tick. With either low, every oscillator tick is a display tick.
- R10: `rst_n` low clears the position to row 0, tick 0, clears the divider and holds all outputs at zero. Outputs stay zero until the first clock edge after release.
- R11: A clock edge without a display tick leaves the frame position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per display oscillator period |
| ext_src | input | 1 | 1 = oscillator comes from an external source |
| prescale_div8 | input | 1 | Divide flag for an external oscillator |
| dot_latch | input | 160 | Latched dot pattern, 8 bits per column, bit 8k+r for column k row r |
| ctrl_word0 | input | 7 | [3:0] brightness code, [5:4] peak-current code, [6] wake |
| blank | input | 1 | 1 = force all columns off |
| row_en | output | 8 | One-hot row sink enable |
| col_en | output | 20 | Column source enables |
| peak_code | output | 2 | Peak-current code for the analog drivers |

## Verification
The bench goes after the edges of the lit window: code 0, which must never light, and code 15, which must run right to the end of the slot. An off-by-one in the gap or window comparison shows as a lit count of 8*T plus or minus 8 per frame. It checks the row 0 slot with every dot set, where a decoder that forgot the missing row would light 20 columns. It also checks a sleep in the middle of a frame, where a design that kept counting would come back at a shifted row. Divided and undivided oscillator modes, and gappy oscillator ticks, are compared against an independent frame-position model. A wrong divider or a counter that advances without a tick therefore drifts out of step within a frame.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_GAP   = 2'd1,
        ST_LIT   = 2'd2,
        ST_DARK  = 2'd3
    } scan_state_e;

    localparam int CODE_W = 4;
    localparam int ON_W   = 7;

    // Lit ticks per row slot for each brightness code (nonlinear).
    function automatic logic [ON_W-1:0] pwm_on_cycles(input logic [CODE_W-1:0] code);
        logic [ON_W-1:0] t;
        unique case (code)
            4'd0:  t = 7'd0;
            4'd1:  t = 7'd1;
            4'd2:  t = 7'd2;
            4'd3:  t = 7'd3;
            4'd4:  t = 7'd4;
            4'd5:  t = 7'd5;
            4'd6:  t = 7'd7;
            4'd7:  t = 7'd9;
            4'd8:  t = 7'd11;
            4'd9:  t = 7'd14;
            4'd10: t = 7'd18;
            4'd11: t = 7'd22;
            4'd12: t = 7'd28;
            4'd13: t = 7'd36;
            4'd14: t = 7'd48;
            4'd15: t = 7'd60;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_tick,
    input  logic divide,
    output logic disp_tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!divide) begin
            pcnt <= '0;
        end else if (run && osc_tick) begin
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
    end

    assign disp_tick = run && osc_tick && (!divide || (pcnt == LAST));

endmodule

// File: rtl/scan_position.sv
module scan_position #(
    parameter int ROWS = 8,
    parameter int SLOT = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      advance,
    output logic [$clog2(ROWS)-1:0]   row_q,
    output logic [$clog2(SLOT)-1:0]   cyc_q,
    output logic [$clog2(ROWS)-1:0]   row_nx,
    output logic [$clog2(SLOT)-1:0]   cyc_nx
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int CYC_W = $clog2(SLOT);

    logic last_cyc;
    logic last_row;

    always_comb begin
        last_cyc = (cyc_q == CYC_W'(SLOT - 1));
        last_row = (row_q == ROW_W'(ROWS - 1));
        cyc_nx   = cyc_q;
        row_nx   = row_q;
        if (advance) begin
            cyc_nx = last_cyc ? '0 : cyc_q + 1'b1;
            if (last_cyc) begin
                row_nx = last_row ? '0 : row_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            cyc_q <= '0;
        end else begin
            row_q <= row_nx;
            cyc_q <= cyc_nx;
        end
    end

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import led_scan_pkg::*;
#(
    parameter int SLOT = 64,
    parameter int GAP  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    awake,
    input  logic [$clog2(SLOT)-1:0] cyc_nx,
    input  logic [ON_W-1:0]         on_cycles,
    output scan_state_e             state,
    output logic                    lit
);
    scan_state_e state_nx;
    scan_state_e slot_phase;

    // Phase that the slot position after this edge belongs to.
    always_comb begin
        int pos;
        pos = int'(cyc_nx);
        if (pos < GAP) begin
            slot_phase = ST_GAP;
        end else if ((pos - GAP) < int'(on_cycles)) begin
            slot_phase = ST_LIT;
        end else begin
            slot_phase = ST_DARK;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP: state_nx = awake ? slot_phase : ST_SLEEP;   // wake
            ST_GAP:   state_nx = awake ? slot_phase : ST_SLEEP;   // light or doze
            ST_LIT:   state_nx = awake ? slot_phase : ST_SLEEP;   // extinguish, next-row or doze
            ST_DARK:  state_nx = awake ? slot_phase : ST_SLEEP;   // next-row or doze
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SLEEP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        lit = (state == ST_LIT);
    end

endmodule

// File: rtl/column_select.sv
module column_select #(
    parameter int COLS     = 20,
    parameter int ROWS     = 8,
    parameter int DARK_ROW = 0
) (
    input  logic [COLS*ROWS-1:0]    dot,
    input  logic [$clog2(ROWS)-1:0] row,
    input  logic                    lit,
    input  logic                    blank,
    output logic [COLS-1:0]         col_en
);
    localparam int ROW_W = $clog2(ROWS);

    logic gate;
    assign gate = lit && !blank && (row != ROW_W'(DARK_ROW));

    for (genvar k = 0; k < COLS; k++) begin : g_col
        logic [ROWS-1:0] bits;
        assign bits      = dot[k*ROWS +: ROWS];
        assign col_en[k] = gate && bits[row];
    end

endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner
    import led_scan_pkg::*;
#(
    parameter int COLS     = 20,
    parameter int ROWS     = 8,
    parameter int SLOT     = 64,
    parameter int GAP      = 4,
    parameter int PRESCALE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_tick,
    input  logic                 ext_src,
    input  logic                 prescale_div8,
    input  logic [COLS*ROWS-1:0] dot_latch,
    input  logic [6:0]           ctrl_word0,
    input  logic                 blank,
    output logic [ROWS-1:0]      row_en,
    output logic [COLS-1:0]      col_en,
    output logic [1:0]           peak_code
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int CYC_W = $clog2(SLOT);

    logic             awake;
    logic             divide;
    logic             disp_tick;
    logic [ROW_W-1:0] row_q;
    logic [CYC_W-1:0] cyc_q;
    logic [ROW_W-1:0] row_nx;
    logic [CYC_W-1:0] cyc_nx;
    logic [ON_W-1:0]  on_cycles;
    scan_state_e      state;
    logic             lit;

    assign awake     = ctrl_word0[6];
    assign divide    = ext_src & prescale_div8;
    assign on_cycles = pwm_on_cycles(ctrl_word0[3:0]);

    scan_tick_gen #(.DIV(PRESCALE)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (awake),
        .osc_tick  (osc_tick),
        .divide    (divide),
        .disp_tick (disp_tick)
    );

    scan_position #(.ROWS(ROWS), .SLOT(SLOT)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (disp_tick),
        .row_q   (row_q),
        .cyc_q   (cyc_q),
        .row_nx  (row_nx),
        .cyc_nx  (cyc_nx)
    );

    scan_phase_fsm #(.SLOT(SLOT), .GAP(GAP)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .awake     (awake),
        .cyc_nx    (cyc_nx),
        .on_cycles (on_cycles),
        .state     (state),
        .lit       (lit)
    );

    column_select #(.COLS(COLS), .ROWS(ROWS), .DARK_ROW(0)) u_cols (
        .dot    (dot_latch),
        .row    (row_q),
        .lit    (lit),
        .blank  (blank),
        .col_en (col_en)
    );

    always_comb begin
        row_en    = lit ? (ROWS'(1) << row_q) : '0;
        peak_code = (state != ST_SLEEP) ? ctrl_word0[5:4] : 2'b00;
    end

endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
    parameter int COLS = 20,
    parameter int ROWS = 8,
    parameter int SLOT = 64,
    parameter int GAP  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    awake,
    input logic                    blank,
    input logic                    disp_tick,
    input logic [$clog2(ROWS)-1:0] row_q,
    input logic [$clog2(SLOT)-1:0] cyc_q,
    input logic [ROWS-1:0]         row_en,
    input logic [COLS-1:0]         col_en,
    input logic [1:0]              peak_code
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int CYC_W = $clog2(SLOT);

    AST_WRAP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_tick && cyc_q == CYC_W'(SLOT - 1) && row_q == ROW_W'(ROWS - 1)) |=> (cyc_q == '0 && row_q == '0)); // R1

    AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < CYC_W'(GAP)) |-> (row_en == '0 && col_en == '0)); // R2

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en)); // R4

    AST_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en != '0) |-> row_en[row_q]); // R4

    AST_DARK_ROW_COLS: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q == '0) |-> (col_en == '0)); // R5

    AST_BLANK_COLS: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (col_en == '0)); // R6

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (row_en == '0 && col_en == '0 && peak_code == 2'b00)); // R7

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> ($stable(cyc_q) && $stable(row_q))); // R7

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_tick |=> ($stable(cyc_q) && $stable(row_q))); // R11

endmodule

bind led_row_scanner led_scan_checker #(
    .COLS(COLS), .ROWS(ROWS), .SLOT(SLOT), .GAP(GAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .awake     (ctrl_word0[6]),
    .blank     (blank),
    .disp_tick (disp_tick),
    .row_q     (row_q),
    .cyc_q     (cyc_q),
    .row_en    (row_en),
    .col_en    (col_en),
    .peak_code (peak_code)
);

// File: tb/sim_led_row_scanner.sv
`timescale 1ns/1ps
module sim_led_row_scanner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         osc_tick = 1'b1;
    logic         ext_src = 1'b0;
    logic         prescale_div8 = 1'b0;
    logic [159:0] dot_latch = '0;
    logic [6:0]   ctrl_word0 = 7'b1_10_1111;
    logic         blank = 1'b0;
    logic [7:0]   row_en;
    logic [19:0]  col_en;
    logic [1:0]   peak_code;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    led_row_scanner u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_src(ext_src),
        .prescale_div8(prescale_div8), .dot_latch(dot_latch), .ctrl_word0(ctrl_word0),
        .blank(blank), .row_en(row_en), .col_en(col_en), .peak_code(peak_code)
    );

    // {brightness code, expected lit ticks per row} (R3)
    localparam logic [11:0] VEC [16] = '{
        {4'd0, 8'd0},  {4'd1, 8'd1},  {4'd2, 8'd2},  {4'd3, 8'd3},
        {4'd4, 8'd4},  {4'd5, 8'd5},  {4'd6, 8'd7},  {4'd7, 8'd9},
        {4'd8, 8'd11}, {4'd9, 8'd14}, {4'd10, 8'd18}, {4'd11, 8'd22},
        {4'd12, 8'd28}, {4'd13, 8'd36}, {4'd14, 8'd48}, {4'd15, 8'd60}
    };

    function automatic int ontime(input logic [3:0] code);
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][11:8] == code) return int'(VEC[i][7:0]);
        end
        return 0;
    endfunction

    function automatic logic [159:0] pattern(input int seed);
        logic [159:0] p;
        for (int j = 0; j < 160; j++) p[j] = (((j * 7) + (seed * 3)) % 5) < 3;
        return p;
    endfunction

    // Frame-position model built from R1, R7, R9, R10, R11
    int         m_idx;
    int         m_pc;
    logic       m_awake;
    logic [3:0] m_pwm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx <= 0; m_pc <= 0; m_awake <= 1'b0; m_pwm <= 4'd0;
        end else begin
            m_awake <= ctrl_word0[6];
            m_pwm   <= ctrl_word0[3:0];
            if (ext_src && prescale_div8) begin
                if (ctrl_word0[6] && osc_tick) begin
                    if (m_pc == 7) begin
                        m_pc  <= 0;
                        m_idx <= (m_idx + 1) % 512;
                    end else begin
                        m_pc <= m_pc + 1;
                    end
                end
            end else begin
                m_pc <= 0;
                if (ctrl_word0[6] && osc_tick) m_idx <= (m_idx + 1) % 512;
            end
        end
    end

    task automatic check_int(input string req, input string what, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Runs n cycles comparing every output against the model; one check per call.
    task automatic run_seg(input int n, input int osc_every, input string req,
                           output int lit_cnt, output int col_cycles, output int row0_cols);
        int bad = 0;
        lit_cnt = 0; col_cycles = 0; row0_cols = 0;
        for (int k = 0; k < n; k++) begin
            int r, c;
            bit lit;
            logic [7:0]  e_row;
            logic [19:0] e_col;
            logic [1:0]  e_peak;
            @(posedge clk); #5;
            r   = m_idx / 64;
            c   = m_idx % 64;
            lit = m_awake && (c >= 4) && ((c - 4) < ontime(m_pwm));
            e_row = lit ? 8'(1 << r) : 8'd0;
            for (int q = 0; q < 20; q++) e_col[q] = lit && (r != 0) && dot_latch[8*q + r] && !blank;
            e_peak = m_awake ? ctrl_word0[5:4] : 2'b00;
            if (row_en != 8'd0) lit_cnt++;
            if (col_en != 20'd0) col_cycles++;
            if (row_en[0] && col_en != 20'd0) row0_cols++;
            if ((row_en !== e_row || col_en !== e_col || peak_code !== e_peak) && bad == 0) begin
                $display("FAIL %s pos %0d: row_en %h/%h col_en %h/%h peak %0d/%0d (got/expected)",
                         req, m_idx, row_en, e_row, col_en, e_col, peak_code, e_peak);
            end
            if (row_en !== e_row || col_en !== e_col || peak_code !== e_peak) bad++;
            osc_tick = ((k + 1) % osc_every) == 0;
        end
        osc_tick = 1'b1;
        tests++;
        if (bad != 0) fails++;
    endtask

    initial begin
        int lc, cc, r0;
        // R10: reset state
        rst_n = 1'b0;
        dot_latch = '1;
        repeat (3) @(posedge clk);
        #5;
        check_int("R10", "row_en in reset", int'(row_en), 0);
        check_int("R10", "col_en in reset", int'(col_en), 0);
        check_int("R10", "peak_code in reset", int'(peak_code), 0);
        rst_n = 1'b1;
        run_seg(10, 1, "R10", lc, cc, r0);

        // Vector table: brightness codes (R1, R3, R4, R5)
        for (int i = 0; i < 16; i++) begin
            ctrl_word0 = {1'b1, 2'(i), VEC[i][11:8]};
            dot_latch  = pattern(i);
            run_seg(512, 1, "R3", lc, cc, r0);
            check_int("R3", "lit ticks per frame", lc, 8 * int'(VEC[i][7:0]));
        end

        // R5: row 0 never lights columns, other rows light all with full dots
        dot_latch  = '1;
        ctrl_word0 = 7'b1_11_1111;
        run_seg(512, 1, "R5", lc, cc, r0);
        check_int("R5", "row 0 column cycles", r0, 0);
        check_int("R5", "column-active cycles", cc, 7 * 60);

        // R6: blank forces columns off, rows unaffected
        blank = 1'b1;
        run_seg(512, 1, "R6", lc, cc, r0);
        check_int("R6", "column cycles while blank", cc, 0);
        check_int("R6", "row lit ticks while blank", lc, 480);
        blank = 1'b0;

        // R8: peak code follows control bits
        for (int p = 0; p < 4; p++) begin
            ctrl_word0 = {1'b1, 2'(p), 4'd13};
            run_seg(40, 1, "R8", lc, cc, r0);
        end

        // R7: sleep mid-frame holds position and goes dark, then resumes
        run_seg(170, 1, "R7", lc, cc, r0);
        ctrl_word0[6] = 1'b0;
        run_seg(150, 1, "R7", lc, cc, r0);
        check_int("R7", "lit ticks while asleep", lc, 0);
        ctrl_word0[6] = 1'b1;
        run_seg(600, 1, "R7", lc, cc, r0);

        // R11: gappy oscillator ticks
        run_seg(1600, 3, "R11", lc, cc, r0);

        // R9: external divide-by-8
        ctrl_word0 = 7'b1_01_1011;
        ext_src = 1'b1; prescale_div8 = 1'b1;
        run_seg(4096, 1, "R9", lc, cc, r0);
        check_int("R9", "lit clocks over 4096 with divide", lc, 8 * 22 * 8);
        // R9: internal source ignores divide flag
        ext_src = 1'b0;
        run_seg(512, 1, "R9", lc, cc, r0);
        check_int("R9", "lit ticks internal source", lc, 8 * 22);
        prescale_div8 = 1'b0;

        // R10, R1: reset mid-frame returns to row 0 tick 0
        run_seg(300, 1, "R1", lc, cc, r0);
        rst_n = 1'b0;
        @(posedge clk); #5;
        check_int("R10", "row_en after mid-run reset", int'(row_en), 0);
        rst_n = 1'b1;
        run_seg(1030, 1, "R1", lc, cc, r0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule